// File: doc/BRIEF.md
# Pipelined Burst Static RAM Model

This block is a synthesizable, cycle-level model of a pipelined synchronous burst SRAM. The depth is parameterized and the data word has four byte lanes. All addresses, write data and strobes are sampled on the rising clock edge. Three inputs act outside that edge: the output enable, the burst-order select and the sleep input.

There are two active-low address strobes, and they may start different commands. The controller strobe can load an address and start a read or a write. The processor strobe can load an address and start only a read, and the primary chip enable blocks it. When neither strobe is asserted, a burst that is already open continues: the advance input steps the two low address bits, and the write enables choose between a read and a write at that address. Read data passes through an output register. Deselection reaches the data bus one cycle later than a read does. The data bus is modelled as a data output plus a drive-enable output, where a low enable stands for high impedance.

A sleep input freezes all internal state and keeps the array contents. After sleep is released, the outputs stay quiet until a read or write command is registered.

Top module: `burst_sram`

## Requirements
- R1: The chip counts as selected only when `en_a_ni` is 0, `en_b_i` is 1 and `en_c_ni` is 0. An accepted strobe while the chip is not selected registers a deselect and ends the open burst.
- R2: With `ctl_strobe_ni` low and the chip selected, `addr_i` is loaded. The command is a write when either write enable is active with at least one lane enabled, and a read otherwise.
- R3: `cpu_strobe_ni` low with `en_a_ni` low loads `addr_i` as a read, even when write enables are active. With `en_a_ni` high the processor strobe is ignored, and an open burst continues as if no strobe were present. A write inside a burst started this way happens only on a later continuation cycle that carries write enables.
- R4: `all_wr_ni` low writes all four lanes, whatever `lane_wr_ni` and `lane_sel_ni` hold.
- R5: With `all_wr_ni` high and `lane_wr_ni` low, lane i (bits 8i+7..8i) is written only when `lane_sel_ni[i]` is 0. The other lanes keep their contents.
- R6: A read registered at edge n shows the array word on `rdata_o`, with `rdata_en_o` high, after edge n+1. Writes registered at edges up to n are included.
- R7: A deselect registered at edge n leaves the previous output driven after edge n+1 and drops `rdata_en_o` after edge n+2, unless a read registered at n+1 drives it again.
- R8: A write registered at edge n drops `rdata_en_o` after edge n+1.
- R9: When no strobe is active and a burst is open, `burst_next_ni` low steps the burst index k (modulo 4), and high repeats the same address. The two low address bits are (start+k) mod 4 when `burst_order_i` is 0, and start xor k when it is 1. The upper bits are kept from the loaded address.
- R10: `out_en_ni` high forces `rdata_en_o` low at once and changes no internal state.
- R11: While `sleep_i` is high, no edge changes state or the array, and `rdata_en_o` is low. After release, `rdata_en_o` stays low until a read or write command is registered.
- R12: After reset, `rdata_en_o` is low and no burst is open, so continuation cycles do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data, four 8-bit lanes |
| ctl_strobe_ni | input | 1 | Controller address strobe (read, write or deselect) |
| cpu_strobe_ni | input | 1 | Processor address strobe (read or deselect) |
| burst_next_ni | input | 1 | Burst advance, active low |
| en_a_ni | input | 1 | Primary chip enable, active low |
| en_b_i | input | 1 | Expansion chip enable, active high |
| en_c_ni | input | 1 | Expansion chip enable, active low |
| all_wr_ni | input | 1 | Write all lanes, active low |
| lane_wr_ni | input | 1 | Write selected lanes, active low |
| lane_sel_ni | input | 4 | Per-lane select, active low |
| out_en_ni | input | 1 | Asynchronous output enable, active low |
| burst_order_i | input | 1 | 0 linear, 1 interleaved burst order |
| sleep_i | input | 1 | Sleep, active high |
| rdata_o | output | 32 | Registered read data |
| rdata_en_o | output | 1 | Data drive enable (low means high impedance) |

## Verification
A wrong command decode or burst index shows at the ports one edge after the next read completes. It appears either as the wrong word on `rdata_o`, or as a lane that did not change when it should have, once that address is read back. An error in the drive-enable pipeline shows within one or two edges of a deselect, write or sleep release, as `rdata_en_o` rising or falling in the wrong cycle. The bench compares both outputs against a behavioural model on every clock, so the first cycle that differs is reported.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2,
    CMD_DSEL = 2'd3
  } cmd_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             interleave_i,
  output logic [CNT_W-1:0] cur_o,
  output logic [CNT_W-1:0] nxt_o
);
  logic [CNT_W-1:0] start_q, cnt_q, cnt_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cnt_q   <= '0;
    end else if (!hold_i) begin
      if (load_i) begin
        start_q <= start_i;
        cnt_q   <= '0;
      end else if (adv_i) begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign cur_o   = interleave_i ? (start_q ^ cnt_q)   : (start_q + cnt_q);
  assign nxt_o   = interleave_i ? (start_q ^ cnt_nxt) : (start_q + cnt_nxt);

  p_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !hold_i) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !hold_i) |=> (cnt_q == '0));
endmodule

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ctl_strobe_ni,
  input  logic             cpu_strobe_ni,
  input  logic             burst_next_ni,
  input  logic             en_a_ni,
  input  logic             en_b_i,
  input  logic             en_c_ni,
  input  logic             all_wr_ni,
  input  logic             lane_wr_ni,
  input  logic [LANES-1:0] lane_sel_ni,
  input  logic             active_i,
  output cmd_e             cmd_o,
  output logic             load_o,
  output logic             adv_o,
  output logic [LANES-1:0] lane_we_o
);
  logic             selected, cpu_take;
  logic [LANES-1:0] mask;

  assign selected = !en_a_ni && en_b_i && !en_c_ni;
  assign cpu_take = !cpu_strobe_ni && !en_a_ni;

  always_comb begin
    if (!all_wr_ni)       mask = '1;
    else if (!lane_wr_ni) mask = ~lane_sel_ni;
    else                  mask = '0;
  end

  always_comb begin
    cmd_o  = CMD_NOP;
    load_o = 1'b0;
    adv_o  = 1'b0;
    if (cpu_take) begin
      load_o = selected;
      cmd_o  = selected ? CMD_RD : CMD_DSEL;
    end else if (!ctl_strobe_ni) begin
      load_o = selected;
      if (!selected)  cmd_o = CMD_DSEL;
      else if (|mask) cmd_o = CMD_WR;
      else            cmd_o = CMD_RD;
    end else if (active_i) begin
      adv_o = !burst_next_ni;
      cmd_o = (|mask) ? CMD_WR : CMD_RD;
    end
    lane_we_o = (cmd_o == CMD_WR) ? mask : '0;
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              hold_i,
  input  logic [LANES-1:0]  we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (!hold_i && we_i[g]) lane_mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W  = LANES * LANE_W,
  localparam int BURST_W = 2,
  localparam int HI_W    = ADDR_W - BURST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ctl_strobe_ni,
  input  logic              cpu_strobe_ni,
  input  logic              burst_next_ni,
  input  logic              en_a_ni,
  input  logic              en_b_i,
  input  logic              en_c_ni,
  input  logic              all_wr_ni,
  input  logic              lane_wr_ni,
  input  logic [LANES-1:0]  lane_sel_ni,
  input  logic              out_en_ni,
  input  logic              burst_order_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_en_o
);
  cmd_e               cmd, cmd1_q;
  logic               load, adv, active_q;
  logic [LANES-1:0]   lane_we, arr_we;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] cur_lo, nxt_lo;
  logic [ADDR_W-1:0]  eff_addr, addr1_q;
  logic [DATA_W-1:0]  arr_rd, out_q;
  logic               drv_q, dsel2_q, doze_q;

  burst_sram_decode #(.LANES(LANES)) u_decode (
    .ctl_strobe_ni (ctl_strobe_ni),
    .cpu_strobe_ni (cpu_strobe_ni),
    .burst_next_ni (burst_next_ni),
    .en_a_ni       (en_a_ni),
    .en_b_i        (en_b_i),
    .en_c_ni       (en_c_ni),
    .all_wr_ni     (all_wr_ni),
    .lane_wr_ni    (lane_wr_ni),
    .lane_sel_ni   (lane_sel_ni),
    .active_i      (active_q),
    .cmd_o         (cmd),
    .load_o        (load),
    .adv_o         (adv),
    .lane_we_o     (lane_we)
  );

  burst_seq #(.CNT_W(BURST_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hold_i       (sleep_i),
    .load_i       (load),
    .adv_i        (adv),
    .start_i      (addr_i[BURST_W-1:0]),
    .interleave_i (burst_order_i),
    .cur_o        (cur_lo),
    .nxt_o        (nxt_lo)
  );

  assign eff_addr = load ? addr_i : {hi_q, (adv ? nxt_lo : cur_lo)};
  assign arr_we   = sleep_i ? '0 : lane_we;

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i   (clk_i),
    .hold_i  (sleep_i),
    .we_i    (arr_we),
    .waddr_i (eff_addr),
    .wdata_i (wdata_i),
    .raddr_i (addr1_q),
    .rdata_o (arr_rd)
  );

  // address / command stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      active_q <= 1'b0;
      cmd1_q   <= CMD_NOP;
      addr1_q  <= '0;
    end else if (!sleep_i) begin
      if (load) hi_q <= addr_i[ADDR_W-1:BURST_W];
      if (cmd == CMD_DSEL) active_q <= 1'b0;
      else if (load)       active_q <= 1'b1;
      cmd1_q  <= cmd;
      addr1_q <= eff_addr;
    end
  end

  // output register stage, deselect lags one more edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      drv_q   <= 1'b0;
      dsel2_q <= 1'b0;
    end else if (!sleep_i) begin
      if (cmd1_q == CMD_RD) begin
        out_q <= arr_rd;
        drv_q <= 1'b1;
      end else if (cmd1_q == CMD_WR || dsel2_q) begin
        drv_q <= 1'b0;
      end
      dsel2_q <= (cmd1_q == CMD_DSEL);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             doze_q <= 1'b0;
    else if (sleep_i)                        doze_q <= 1'b1;
    else if (cmd == CMD_RD || cmd == CMD_WR) doze_q <= 1'b0;
  end

  assign rdata_o    = out_q;
  assign rdata_en_o = drv_q && !out_en_ni && !sleep_i && !doze_q;

  p_read_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd1_q == CMD_RD && !sleep_i) |=> drv_q);
  p_dsel_late_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsel2_q && cmd1_q != CMD_RD && !sleep_i) |=> !drv_q);
  p_write_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd1_q == CMD_WR && !sleep_i) |=> !drv_q);
  p_sleep_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(drv_q) && $stable(active_q) && $stable(addr1_q)));

  always_comb begin
    if (rst_ni && cmd == CMD_WR && !all_wr_ni)
      p_global_all_r4: assert (&lane_we);
    if (rst_ni && !cpu_strobe_ni && !en_a_ni)
      p_cpu_no_write_r3: assert (cmd != CMD_WR && lane_we == '0);
  end
endmodule

// File: tb/burst_sram_test.sv
module burst_sram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ctl_n = 1'b1, cpu_n = 1'b1, nxt_n = 1'b1;
  logic        ea_n = 1'b0, eb = 1'b1, ec_n = 1'b0;
  logic        gw_n = 1'b1, lw_n = 1'b1;
  logic [3:0]  sel_n = 4'hf;
  logic        oe_n = 1'b0, order = 1'b0, sleep = 1'b0;
  logic [31:0] rdata;
  logic        rdata_en;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur = "R12";

  always #5 clk = ~clk;

  burst_sram uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .ctl_strobe_ni(ctl_n), .cpu_strobe_ni(cpu_n), .burst_next_ni(nxt_n),
    .en_a_ni(ea_n), .en_b_i(eb), .en_c_ni(ec_n),
    .all_wr_ni(gw_n), .lane_wr_ni(lw_n), .lane_sel_ni(sel_n),
    .out_en_ni(oe_n), .burst_order_i(order), .sleep_i(sleep),
    .rdata_o(rdata), .rdata_en_o(rdata_en)
  );

  // behavioural reference
  logic [31:0] m_mem [64];
  logic [31:0] m_out;
  int  m_c1, m_a1, m_hi, m_s, m_k;
  bit  m_act, m_drv, m_d2, m_doze;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_c1 = 0; m_a1 = 0; m_hi = 0; m_s = 0; m_k = 0;
      m_act = 0; m_drv = 0; m_d2 = 0; m_doze = 0; m_out = '0;
    end else if (sleep) begin
      m_doze = 1;
    end else begin
      int c, a;
      bit sel, start;
      logic [3:0] wm;
      if (m_c1 == 1) begin m_out = m_mem[m_a1]; m_drv = 1; end
      else if (m_c1 == 2 || m_d2) m_drv = 0;
      m_d2 = (m_c1 == 3);
      sel = (ea_n == 0) && (eb == 1) && (ec_n == 0);
      wm = !gw_n ? 4'hf : (!lw_n ? ~sel_n : 4'h0);
      c = 0; start = 0;
      if (!cpu_n && !ea_n) begin
        if (sel) begin c = 1; start = 1; end else c = 3;
      end else if (!ctl_n) begin
        if (sel) begin c = (wm != 0) ? 2 : 1; start = 1; end else c = 3;
      end else if (m_act) begin
        if (!nxt_n) m_k = (m_k + 1) % 4;
        c = (wm != 0) ? 2 : 1;
      end
      if (start) begin m_hi = int'(addr) / 4; m_s = int'(addr) % 4; m_k = 0; m_act = 1; end
      if (c == 3) m_act = 0;
      a = m_hi * 4 + (order ? (m_s ^ m_k) : ((m_s + m_k) % 4));
      if (c == 2)
        for (int i = 0; i < 4; i++) if (wm[i]) m_mem[a][8*i +: 8] = wdata[8*i +: 8];
      if (c == 1 || c == 2) m_doze = 0;
      m_c1 = c; m_a1 = a;
    end
  end

  task automatic compare();
    bit exp_en;
    exp_en = m_drv && !oe_n && !sleep && !m_doze;
    tests++;
    if (rdata_en !== exp_en) begin
      fails++;
      $display("FAIL %s: rdata_en_o=%0b expected %0b at %0t", cur, rdata_en, exp_en, $time);
    end else if (exp_en && !$isunknown(m_out) && rdata !== m_out) begin
      fails++;
      $display("FAIL %s: rdata_o=%h expected %h at %0t", cur, rdata, m_out, $time);
    end
  endtask

  task automatic tick(string tag);
    cur = tag;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    ctl_n = 1; cpu_n = 1; nxt_n = 1; gw_n = 1; lw_n = 1; sel_n = 4'hf;
    ea_n = 0; eb = 1; ec_n = 0;
  endtask

  task automatic wr_set(int wk, logic [31:0] d, logic [3:0] s);
    wdata = d;
    if (wk == 1) gw_n = 0;
    if (wk == 2) begin lw_n = 0; sel_n = s; end
  endtask

  task automatic ctl(int a, int wk, logic [31:0] d, logic [3:0] s, string tag);
    idle(); ctl_n = 0; addr = 6'(a); wr_set(wk, d, s); tick(tag);
  endtask

  task automatic cpu(int a, int wk, logic [31:0] d, string tag);
    idle(); cpu_n = 0; addr = 6'(a); wr_set(wk, d, 4'h0); tick(tag);
  endtask

  task automatic cont(bit adv, int wk, logic [31:0] d, logic [3:0] s, string tag);
    idle(); nxt_n = !adv; wr_set(wk, d, s); tick(tag);
  endtask

  initial begin
    @(negedge clk);
    repeat (3) tick("R12");
    rst_n = 1;
    idle(); nxt_n = 0;
    tick("R12"); tick("R12");
    // fill 4..7 and 12..15
    ctl(4, 1, 32'h11223344, 4'hf, "R2");
    cont(1, 2, 32'hA5A5A5A5, 4'h0, "R5");
    cont(1, 1, 32'h0BADF00D, 4'hf, "R4");
    cont(1, 2, 32'h77665544, 4'h0, "R8");
    ctl(12, 2, 32'hC0C1C2C3, 4'h0, "R2");
    cont(1, 1, 32'hD0D1D2D3, 4'h5, "R4");
    cont(1, 1, 32'hE0E1E2E3, 4'h5, "R4");
    cont(1, 1, 32'hF0F1F2F3, 4'h5, "R4");
    // linear read burst
    ctl(4, 0, '0, 4'hf, "R2");
    for (int i = 0; i < 3; i++) cont(1, 0, '0, 4'hf, "R9");
    cont(0, 0, '0, 4'hf, "R6"); cont(0, 0, '0, 4'hf, "R6");
    // interleaved burst from low bits 2
    order = 1;
    cpu(6, 0, '0, "R3");
    for (int i = 0; i < 3; i++) cont(1, 0, '0, 4'hf, "R9");
    cont(0, 0, '0, 4'hf, "R9");
    order = 0;
    // processor strobe with write enables: read only, write on next cycle
    cpu(12, 1, 32'h99999999, "R3");
    cont(1, 1, 32'hDEAD0001, 4'hf, "R3");
    ctl(12, 0, '0, 4'hf, "R3");
    cont(1, 0, '0, 4'hf, "R3");
    cont(0, 0, '0, 4'hf, "R3");
    // partial lane write
    ctl(5, 2, 32'hFFFFFFFF, 4'b1010, "R5");
    ctl(5, 0, '0, 4'hf, "R5");
    cont(0, 0, '0, 4'hf, "R5"); cont(0, 0, '0, 4'hf, "R5");
    // deselect by each enable
    ctl(4, 0, '0, 4'hf, "R7");
    idle(); ctl_n = 0; eb = 0; tick("R1");
    idle(); tick("R7"); tick("R7"); tick("R7");
    ctl(6, 0, '0, 4'hf, "R1");
    idle(); ctl_n = 0; ec_n = 1; tick("R1");
    idle(); nxt_n = 0; tick("R1"); tick("R1"); tick("R1");
    ctl(7, 0, '0, 4'hf, "R1");
    idle(); cpu_n = 0; eb = 0; tick("R1");
    idle(); tick("R7"); tick("R7");
    // write directly after read
    ctl(4, 0, '0, 4'hf, "R8");
    ctl(8, 1, 32'h12345678, 4'hf, "R8");
    idle(); tick("R8"); tick("R8");
    // blocked processor strobe
    ctl(4, 0, '0, 4'hf, "R3");
    idle(); cpu_n = 0; ea_n = 1; nxt_n = 0; tick("R3");
    idle(); cpu_n = 0; ea_n = 1; nxt_n = 0; tick("R3");
    cont(0, 0, '0, 4'hf, "R3"); cont(0, 0, '0, 4'hf, "R3");
    // linear wrap
    ctl(7, 0, '0, 4'hf, "R9");
    for (int i = 0; i < 5; i++) cont(1, 0, '0, 4'hf, "R9");
    // output enable
    oe_n = 1; cont(0, 0, '0, 4'hf, "R10"); cont(1, 0, '0, 4'hf, "R10");
    oe_n = 0; cont(0, 0, '0, 4'hf, "R10");
    // sleep
    ctl(4, 0, '0, 4'hf, "R11");
    cont(0, 0, '0, 4'hf, "R11");
    sleep = 1;
    for (int i = 0; i < 3; i++) cont(1, 1, 32'h5A5A5A5A, 4'hf, "R11");
    sleep = 0;
    idle(); ctl_n = 0; eb = 0; tick("R11");
    idle(); tick("R11"); tick("R11");
    ctl(5, 0, '0, 4'hf, "R11");
    cont(1, 0, '0, 4'hf, "R11");
    cont(0, 0, '0, 4'hf, "R11"); cont(0, 0, '0, 4'hf, "R11");
    // reset while a burst is open
    rst_n = 0; tick("R12");
    rst_n = 1; idle(); nxt_n = 0; tick("R12"); tick("R12");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, at %s", cur);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule